// File: doc/BRIEF.md
# Four-Bank SDRAM Command Front End

This block sits on the memory side of a four-bank DDR SDRAM model and interprets the command bus. On every rising clock edge it samples chip select, the row, column and write strobes, the two bank-select bits, a 13-bit address and clock enable. It then produces a registered command strobe with the target bank and the row, column or op-code that the command carries.

Alongside the decode it keeps track of which banks are open and which row each open bank holds. It also stores the op-code of each mode register and follows the device through precharge power-down, active power-down and self refresh. Address bit 10 has three uses. On a read or write it requests auto-precharge, on a precharge it selects all banks, and on a mode load it is simply part of the op-code. A sticky error flag records commands that break the bank protocol.

All outputs are registered. A command sampled at one rising edge appears on the outputs from that edge until the next.

Top module: `sdram_cmd_front`

## Requirements
- R1: When chip select is high, or the strobe code {row, column, write} is 111 or 110, no command is decoded. In the following cycle `cmd_vld_o` is 0, `cmd_o` is 111, and `bank_o`, `addr_o`, `ap_o` and `open_row_o` are 0.
- R2: A decoded command raises `cmd_vld_o` for exactly the cycle after its sampling edge, with `cmd_o` equal to the strobe code. The codes are: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode load. Auto refresh drives `bank_o` and `addr_o` to 0.
- R3: Activate drives `bank_o` with the bank bits and `addr_o` with the full 13-bit row. It opens that bank (bit b of `bank_open_o`) and stores the row.
- R4: Read and write drive `addr_o` with address bits 9:0 zero-extended, `ap_o` with address bit 10, and `open_row_o` with the row stored for the target bank.
- R5: A read or write with bit 10 set to an open bank closes that bank one cycle after its output cycle. A command sampled at the next edge already sees that bank as idle.
- R6: Precharge drives `ap_o` with address bit 10 and `bank_o` with the bank bits. With bit 10 low it closes only that bank; with bit 10 high it closes all banks.
- R7: Mode load drives `addr_o` with the op-code. From the next cycle it writes the op-code into the 13-bit field at `mode_ops_o[ba*13 +: 13]`; the other fields keep their values.
- R8: Power state `pwr_o` is 00 for running, 01 for precharge power-down, 10 for active power-down and 11 for self refresh. Clock enable sampled low while running enters 11 if the auto refresh code is present with chip select low. Otherwise it enters 10 if any bank is open, and 01 if none is. Clock enable sampled high in any low-power state returns to 00.
- R9: A command is ignored if it is sampled with clock enable low, or while the power state is not 00. This includes the edge that enters or leaves a low-power state. An ignored command gives no strobe and changes no bank or mode state.
- R10: `proto_err_o` is set by an activate to an open bank, or by a read or write to an idle bank. It stays set until reset.
- R11: After reset all banks are idle, stored rows are 0, the mode fields are 0, `pwr_o` is 00, `proto_err_o` is 0 and the outputs are as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank / mode register select |
| addr_i | input | 13 | Address / op-code |
| cmd_vld_o | output | 1 | Decoded command strobe |
| cmd_o | output | 3 | Decoded strobe code |
| bank_o | output | 2 | Target bank |
| addr_o | output | 13 | Row, column or op-code |
| ap_o | output | 1 | Auto-precharge (read/write) or all-banks (precharge) |
| open_row_o | output | 13 | Stored row of the target bank on read/write |
| bank_open_o | output | 4 | Open flag per bank |
| pwr_o | output | 2 | Power state |
| proto_err_o | output | 1 | Sticky protocol error |
| mode_ops_o | output | 52 | Four 13-bit mode op-code fields |

## Verification
Directed sequences exercise each command with addresses whose upper bits and bit 10 differ. This shows whether the column is masked correctly and whether bit 10 is routed to the right role. Back-to-back patterns follow an auto-precharge with an activate to the same bank, which checks that the bank has closed by then. Power entry is tried with all banks idle, with one bank open, and with the refresh code present, which distinguishes the three low-power states. Commands placed on entry and exit edges confirm they are ignored. A long random stream then compares every output against a behavioural model in every cycle.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CODE_MODE = 3'b000,
    CODE_REFR = 3'b001,
    CODE_PCHG = 3'b010,
    CODE_ACTV = 3'b011,
    CODE_WRIT = 3'b100,
    CODE_READ = 3'b101,
    CODE_BSTP = 3'b110,
    CODE_IDLE = 3'b111
  } cmd_code_e;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_PPD  = 2'b01,
    PWR_APD  = 2'b10,
    PWR_SREF = 2'b11
  } pwr_e;

endpackage

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int NB = 4,
  parameter int RW = 13,
  parameter int BW = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   act_i,
  input  logic                   rd_wr_i,
  input  logic                   pre_i,
  input  logic [BW-1:0]          bank_i,
  input  logic [RW-1:0]          row_i,
  input  logic                   flag_i,
  output logic [NB-1:0]          open_o,
  output logic [NB-1:0]          eff_open_o,
  output logic [NB-1:0][RW-1:0]  rows_o,
  output logic                   err_o
);

  logic [NB-1:0]         open_q;
  logic [NB-1:0]         pend_q;
  logic [NB-1:0][RW-1:0] row_q;
  logic [NB-1:0]         sel;
  logic                  err_q;
  logic                  tgt_open;

  always_comb begin
    sel = '0;
    sel[bank_i] = 1'b1;
  end

  // a pending auto-precharge is applied before the new command is judged
  assign eff_open_o = open_q & ~pend_q;
  assign tgt_open   = |(sel & eff_open_o);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open_q[b] <= 1'b0;
        pend_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else begin
        pend_q[b] <= rd_wr_i && flag_i && sel[b] && eff_open_o[b];
        if (act_i && sel[b]) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= row_i;
        end else if (pre_i && (flag_i || sel[b])) begin
          open_q[b] <= 1'b0;
        end else if (pend_q[b]) begin
          open_q[b] <= 1'b0;
        end
      end
    end

    // R3
    act_row_chk: assert property (@(posedge clk) disable iff (rst)
      (act_i && sel[b]) |=> (open_q[b] && row_q[b] == $past(row_i)));

    // R5
    ap_close_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_wr_i && flag_i && sel[b] && eff_open_o[b]) |=> !eff_open_o[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if ((act_i && tgt_open) || (rd_wr_i && !tgt_open)) err_q <= 1'b1;
  end

  assign open_o = open_q;
  assign rows_o = row_q;
  assign err_o  = err_q;

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_i && flag_i) |=> (open_q == '0));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

endmodule

// File: rtl/sdram_power_fsm.sv
module sdram_power_fsm
  import sdram_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke_i,
  input  logic sref_req_i,
  input  logic any_open_i,
  output pwr_e state_o,
  output logic run_o
);

  pwr_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PWR_RUN;
    end else begin
      case (st_q)
        PWR_RUN: begin
          if (!cke_i) begin
            if (sref_req_i)      st_q <= PWR_SREF;
            else if (any_open_i) st_q <= PWR_APD;
            else                 st_q <= PWR_PPD;
          end
        end
        default: if (cke_i) st_q <= PWR_RUN;
      endcase
    end
  end

  assign state_o = st_q;
  assign run_o   = (st_q == PWR_RUN) && cke_i;

  // R8
  ppd_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PWR_PPD) |=> (st_q == PWR_PPD || st_q == PWR_RUN));

  // R8
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != PWR_RUN && cke_i) |=> (st_q == PWR_RUN));

endmodule

// File: rtl/sdram_mode_file.sv
module sdram_mode_file #(
  parameter int NR = 4,
  parameter int W  = 13,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  logic [W-1:0]  op_i,
  output logic [NR*W-1:0] regs_o
);

  logic [NR-1:0][W-1:0] regs_q;

  for (genvar r = 0; r < NR; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                              regs_q[r] <= '0;
      else if (we_i && sel_i == SW'(r))     regs_q[r] <= op_i;
    end
  end

  assign regs_o = regs_q;

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(regs_q));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cke_i,
  input  logic                        cs_n_i,
  input  logic                        ras_n_i,
  input  logic                        cas_n_i,
  input  logic                        we_n_i,
  input  logic [BA_W-1:0]             ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        cmd_vld_o,
  output logic [2:0]                  cmd_o,
  output logic [BA_W-1:0]             bank_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        ap_o,
  output logic [ADDR_W-1:0]           open_row_o,
  output logic [NUM_BANKS-1:0]        bank_open_o,
  output logic [1:0]                  pwr_o,
  output logic                        proto_err_o,
  output logic [NUM_BANKS*ADDR_W-1:0] mode_ops_o
);

  localparam int PAD_W = ADDR_W - COL_W;

  cmd_code_e code;
  logic      run, live, is_act, is_rdwr, is_pre, is_mode, is_ref, sref_req;
  logic [NUM_BANKS-1:0]             eff_open;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] rows;
  pwr_e      pwr_st;

  assign code     = cmd_code_e'({ras_n_i, cas_n_i, we_n_i});
  assign sref_req = !cs_n_i && (code == CODE_REFR);
  assign live     = run && !cs_n_i && (code != CODE_IDLE) && (code != CODE_BSTP);
  assign is_act   = live && (code == CODE_ACTV);
  assign is_rdwr  = live && (code == CODE_READ || code == CODE_WRIT);
  assign is_pre   = live && (code == CODE_PCHG);
  assign is_mode  = live && (code == CODE_MODE);
  assign is_ref   = live && (code == CODE_REFR);

  sdram_bank_table #(.NB(NUM_BANKS), .RW(ADDR_W), .BW(BA_W)) u_banks (
    .clk        (clk),
    .rst        (rst),
    .act_i      (is_act),
    .rd_wr_i    (is_rdwr),
    .pre_i      (is_pre),
    .bank_i     (ba_i),
    .row_i      (addr_i),
    .flag_i     (addr_i[AP_BIT]),
    .open_o     (bank_open_o),
    .eff_open_o (eff_open),
    .rows_o     (rows),
    .err_o      (proto_err_o)
  );

  sdram_power_fsm u_pwr (
    .clk        (clk),
    .rst        (rst),
    .cke_i      (cke_i),
    .sref_req_i (sref_req),
    .any_open_i (|eff_open),
    .state_o    (pwr_st),
    .run_o      (run)
  );

  sdram_mode_file #(.NR(NUM_BANKS), .W(ADDR_W), .SW(BA_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .we_i   (is_mode),
    .sel_i  (ba_i),
    .op_i   (addr_i),
    .regs_o (mode_ops_o)
  );

  assign pwr_o = pwr_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld_o  <= 1'b0;
      cmd_o      <= CODE_IDLE;
      bank_o     <= '0;
      addr_o     <= '0;
      ap_o       <= 1'b0;
      open_row_o <= '0;
    end else begin
      cmd_vld_o  <= live;
      cmd_o      <= live ? code : CODE_IDLE;
      bank_o     <= (live && !is_ref) ? ba_i : '0;
      ap_o       <= (is_rdwr || is_pre) ? addr_i[AP_BIT] : 1'b0;
      open_row_o <= is_rdwr ? rows[ba_i] : '0;
      if (is_act || is_mode) addr_o <= addr_i;
      else if (is_rdwr)      addr_o <= {{PAD_W{1'b0}}, addr_i[COL_W-1:0]};
      else                   addr_o <= '0;
    end
  end

  // R9
  run_only_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |-> ($past(pwr_o) == 2'b00 && $past(cke_i)));

  // R1
  vld_code_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |-> (cmd_o != 3'b111 && cmd_o != 3'b110));

  // R2
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i || !cke_i) |=> !cmd_vld_o);

endmodule

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [12:0] addr_i = '0;
  logic        cmd_vld_o, ap_o, proto_err_o;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o, pwr_o;
  logic [12:0] addr_o, open_row_o;
  logic [3:0]  bank_open_o;
  logic [51:0] mode_ops_o;

  always #2.5 clk = ~clk;

  sdram_cmd_front u_dut (
    .clk(clk), .rst(rst), .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .ba_i(ba_i), .addr_i(addr_i),
    .cmd_vld_o(cmd_vld_o), .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o),
    .ap_o(ap_o), .open_row_o(open_row_o), .bank_open_o(bank_open_o),
    .pwr_o(pwr_o), .proto_err_o(proto_err_o), .mode_ops_o(mode_ops_o)
  );

  int    vectors = 0, fails = 0, cyc = 0;
  bit    started = 0, done = 0;
  string cur_req = "R11";

  // behavioural reference
  int m_open[4], m_row[4], m_mode[4];
  int m_pend = -1, m_pwr = 0, m_err = 0;
  int e_vld, e_cmd, e_bank, e_addr, e_ap, e_orow;

  always @(posedge clk) begin
    int code, anyo;
    started = 1;
    e_vld = 0; e_cmd = 7; e_bank = 0; e_addr = 0; e_ap = 0; e_orow = 0;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; m_mode[i] = 0; end
      m_pend = -1; m_pwr = 0; m_err = 0;
    end else begin
      code = {ras_n_i, cas_n_i, we_n_i};
      if (m_pend >= 0) begin m_open[m_pend] = 0; m_pend = -1; end
      anyo = 0;
      for (int i = 0; i < 4; i++) anyo |= m_open[i];
      if (m_pwr == 0) begin
        if (!cke_i) begin
          if (!cs_n_i && code == 1) m_pwr = 3;
          else m_pwr = anyo ? 2 : 1;
        end else if (!cs_n_i && code < 6) begin
          e_vld = 1; e_cmd = code;
          case (code)
            3: begin
              e_bank = ba_i; e_addr = addr_i;
              if (m_open[ba_i]) m_err = 1;
              m_open[ba_i] = 1; m_row[ba_i] = addr_i;
            end
            4, 5: begin
              e_bank = ba_i; e_addr = addr_i & 13'h3FF; e_ap = addr_i[10];
              e_orow = m_row[ba_i];
              if (!m_open[ba_i]) m_err = 1;
              else if (addr_i[10]) m_pend = ba_i;
            end
            2: begin
              e_bank = ba_i; e_ap = addr_i[10];
              if (addr_i[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
              else m_open[ba_i] = 0;
            end
            0: begin
              e_bank = ba_i; e_addr = addr_i; m_mode[ba_i] = addr_i;
            end
            default: ;
          endcase
        end
      end else if (cke_i) begin
        m_pwr = 0;
      end
    end
  end

  task automatic chk(input string nm, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int eo;
      eo = 0;
      for (int i = 0; i < 4; i++) eo |= m_open[i] << i;
      chk("cmd_vld", cmd_vld_o, e_vld);
      chk("cmd", cmd_o, e_cmd);
      chk("bank", bank_o, e_bank);
      chk("addr", addr_o, e_addr);
      chk("ap", ap_o, e_ap);
      chk("open_row", open_row_o, e_orow);
      chk("bank_open", bank_open_o, eo);
      chk("pwr", pwr_o, m_pwr);
      chk("err", proto_err_o, m_err);
      for (int i = 0; i < 4; i++) chk("mode", mode_ops_o[i*13 +: 13], m_mode[i]);
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic drv(input bit cke, input bit cs, input bit [2:0] code,
                     input bit [1:0] ba, input bit [12:0] a);
    @(negedge clk);
    cke_i = cke; cs_n_i = cs; {ras_n_i, cas_n_i, we_n_i} = code; ba_i = ba; addr_i = a;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drv(1, 0, 3'b111, 0, 0);
  endtask

  initial begin
    drv(1, 1, 3'b111, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nop(2);

    cur_req = "R1";
    drv(1, 1, 3'b011, 1, 13'h0123);
    drv(1, 0, 3'b111, 2, 13'h1FFF);
    drv(1, 0, 3'b110, 3, 13'h0555);
    nop(1);

    cur_req = "R3";
    drv(1, 0, 3'b011, 0, 13'h1ABC);
    drv(1, 0, 3'b011, 2, 13'h0F0F);
    nop(1);

    cur_req = "R4";
    drv(1, 0, 3'b101, 0, 13'h03FF);
    drv(1, 0, 3'b100, 2, 13'h1A55);
    nop(1);

    cur_req = "R2";
    drv(1, 0, 3'b001, 3, 13'h1234);
    nop(1);

    cur_req = "R5";
    drv(1, 0, 3'b101, 0, 13'h0407);
    drv(1, 0, 3'b011, 0, 13'h0111);
    drv(1, 0, 3'b100, 0, 13'h1C01);
    nop(2);

    cur_req = "R6";
    drv(1, 0, 3'b010, 2, 13'h0000);
    drv(1, 0, 3'b011, 1, 13'h0AAA);
    drv(1, 0, 3'b011, 3, 13'h1555);
    drv(1, 0, 3'b010, 0, 13'h0400);
    nop(1);

    cur_req = "R7";
    drv(1, 0, 3'b000, 0, 13'h0033);
    drv(1, 0, 3'b000, 2, 13'h1421);
    nop(1);

    cur_req = "R8";
    drv(0, 0, 3'b111, 0, 0);
    drv(0, 0, 3'b111, 0, 0);
    drv(1, 0, 3'b111, 0, 0);
    drv(1, 0, 3'b011, 1, 13'h0042);
    drv(0, 0, 3'b111, 0, 0);
    drv(0, 0, 3'b111, 0, 0);
    cur_req = "R9";
    drv(0, 0, 3'b011, 3, 13'h0999);
    drv(1, 0, 3'b010, 1, 13'h0400);
    drv(1, 0, 3'b010, 0, 13'h0400);
    cur_req = "R8";
    drv(0, 0, 3'b001, 0, 0);
    cur_req = "R9";
    drv(0, 0, 3'b000, 1, 13'h0777);
    drv(1, 0, 3'b000, 1, 13'h0666);
    drv(0, 0, 3'b000, 3, 13'h0321);
    drv(1, 0, 3'b111, 0, 0);
    nop(1);

    cur_req = "R10";
    drv(1, 0, 3'b101, 2, 13'h0001);
    drv(1, 0, 3'b011, 2, 13'h0010);
    drv(1, 0, 3'b011, 2, 13'h0020);
    nop(1);

    cur_req = "R11";
    drv(1, 0, 3'b011, 1, 13'h0FFF);
    @(negedge clk); rst = 1'b1;
    nop(2);
    @(negedge clk); rst = 1'b0;
    nop(1);

    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drv(r < 92, $urandom_range(0, 99) < 12, 3'($urandom_range(0, 7)),
          2'($urandom_range(0, 3)), 13'($urandom_range(0, 8191)));
    end
    nop(2);

    done = 1;
    summary();
    $finish;
  end

endmodule